// File: doc/BRIEF.md
# Masked Device Interrupt Router

The router collects up to 64 device interrupt request lines into one pending-request summary and delivers them to up to four CPUs. Each source has a one-cycle set pulse and a one-cycle clear pulse. A clear pulse for a source that is not pending is spurious and is ignored. Each CPU owns an enable mask as wide as the summary. Its effective vector is the summary ANDed with that mask. One device-interrupt level per CPU is the OR of that CPU's effective vector.

Software reaches the block through a 64-bit register port. A request is presented for one cycle, and a response follows exactly one cycle later. The port serves two address maps:

- **Direct map.** Registers sit at 64-byte strides: index = offset >> 6.
- **Window map.** Two high offset bits open windows onto the masks and the effective vectors. The CPU index sits in a 6-bit field.

Every mask write and every source event brings the effective vectors and the CPU levels up to date, so they always track the current mask and summary.

Top module: `irq_router`

## Requirements
- R1: A one-cycle pulse on `srcSet[n]` sets summary bit n at the next clock edge. Every CPU whose mask has bit n set then drives `devIrq` high from that edge on.
- R2: Each CPU's effective vector equals its mask ANDed with the summary after every clock edge. This holds whatever mix of mask writes and source events occurred.
- R3: A legal mask write replaces that CPU's mask at the clock edge of the request.
  - Enabling a pending source raises that CPU's `devIrq`.
  - Disabling the last pending enabled source drops it.
  - A source event in the same cycle is combined with the new mask.
- R4: A pulse on `srcClr[n]` while summary bit n is 1 clears the bit. The source is then withdrawn from every CPU. A CPU's `devIrq` falls when no other effective bit remains.
- R5: A pulse on `srcClr[n]` while summary bit n is 0 is spurious and changes no state.
- R6: When `srcSet[n]` and `srcClr[n]` pulse in the same cycle, the set wins and summary bit n is 1 afterwards.
- R7: Every request (`regValid`=1) produces `rspValid`=1 one cycle later, and no response appears otherwise. The direct map is decoded as index = offset >> 6:
  - index 0: summary (read-only);
  - indices 1..NUM_CPU: mask of CPU index-1 (read/write);
  - indices NUM_CPU+1..2*NUM_CPU: effective vector of CPU index-NUM_CPU-1 (read-only).

  Read data reflects the state before the request's clock edge.
- R8: If offset bit 15 is set, the access targets the mask of the CPU given in offset bits 9:4. If only offset bit 14 is set, it is a read of that CPU's effective vector. Bit 15 takes priority when both are set.
- R9: Each of the following gives `rspErr`=1, `rspData`=0 and no change to any state:
  - a request with `regBytes`≠8;
  - a direct offset that is not a multiple of 64;
  - a window offset with any of bits 13:10 or 3:0 set;
  - a CPU index ≥ NUM_CPU;
  - a direct index beyond 2*NUM_CPU;
  - a write to the summary or to an effective vector.
- R10: `devIrq[c]` is a register equal to the OR of CPU c's effective vector. It is 0 after reset, as are the summary and all masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSet | input | NUM_SRC | Per-source set pulses |
| srcClr | input | NUM_SRC | Per-source clear pulses |
| regValid | input | 1 | Register request valid |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset of the access |
| regBytes | input | 4 | Access size in bytes; only 8 is legal |
| regWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspErr | output | 1 | Illegal access |
| rspData | output | DATA_W | Read data, 0 on writes and errors |
| devIrq | output | NUM_CPU | Device-interrupt level per CPU |

## Verification
Three kinds of update can land in the same clock cycle:

- a mask write;
- a set pulse;
- a clear pulse, possibly for the very source that the write enables or disables.

The bench provokes this in directed cycles: a set and a clear on one source together, and a mask write issued alongside a set. It also provokes it in a long random phase that drives sparse set and clear pulses together with legal and illegal register traffic. A behavioural model applies the write first, then the clear and then the set. Every clock it judges `devIrq` and the response fields against the model, and reads of the effective vectors expose the combined result.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SUM  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_EFF  = 2'd3
  } rd_sel_e;

  // strobes from the access decoder to the datapath
  typedef struct packed {
    logic             ack;
    logic             err;
    logic             wrMask;
    rd_sel_e          rdSel;
    logic [IDX_W-1:0] idx;
  } reg_stb_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 16
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regBytes,
  output reg_stb_t          stb
);
  localparam int MASK_WIN_BIT = ADDR_W - 1;
  localparam int EFF_WIN_BIT  = ADDR_W - 2;
  localparam int REG_SHIFT    = 6;
  localparam int WIN_LSB      = 4;
  localparam int WIN_W        = 6;
  localparam int WIN_MSB      = WIN_LSB + WIN_W - 1;
  localparam int DIR_W        = EFF_WIN_BIT - REG_SHIFT;

  logic [WIN_W-1:0] winIdx;
  logic [DIR_W-1:0] dirIdx;
  logic             inWindow;
  logic             bad;
  rd_sel_e          kind;
  logic [IDX_W-1:0] idxSel;

  assign winIdx   = regAddr[WIN_MSB:WIN_LSB];
  assign dirIdx   = regAddr[EFF_WIN_BIT-1:REG_SHIFT];
  assign inWindow = regAddr[MASK_WIN_BIT] | regAddr[EFF_WIN_BIT];

  always_comb begin
    bad    = (regBytes != 4'd8);
    kind   = SEL_NONE;
    idxSel = '0;
    if (inWindow) begin
      idxSel = IDX_W'(winIdx);
      kind   = regAddr[MASK_WIN_BIT] ? SEL_MASK : SEL_EFF;
      if (regAddr[WIN_LSB-1:0] != '0)                bad = 1'b1;
      if (regAddr[EFF_WIN_BIT-1:WIN_MSB+1] != '0)     bad = 1'b1;
      if (int'(winIdx) >= NUM_CPU)                    bad = 1'b1;
    end else begin
      if (regAddr[REG_SHIFT-1:0] != '0) bad = 1'b1;
      if (dirIdx == '0) begin
        kind = SEL_SUM;
      end else if (int'(dirIdx) <= NUM_CPU) begin
        kind   = SEL_MASK;
        idxSel = IDX_W'(int'(dirIdx) - 1);
      end else if (int'(dirIdx) <= 2 * NUM_CPU) begin
        kind   = SEL_EFF;
        idxSel = IDX_W'(int'(dirIdx) - 1 - NUM_CPU);
      end else begin
        bad = 1'b1;
      end
    end
    if (regWrite && kind != SEL_MASK) bad = 1'b1;
  end

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    if (regValid) begin
      stb.ack = 1'b1;
      stb.idx = idxSel;
      if (bad)           stb.err    = 1'b1;
      else if (regWrite) stb.wrMask = 1'b1;
      else               stb.rdSel  = kind;
    end
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_SRC-1:0]                srcSet,
  input  logic [NUM_SRC-1:0]                srcClr,
  input  reg_stb_t                          stb,
  input  logic [DATA_W-1:0]                 regWdata,
  output logic                              rspValid,
  output logic                              rspErr,
  output logic [DATA_W-1:0]                 rspData,
  output logic [NUM_SRC-1:0]                summaryQ,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   maskQ,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   effQ,
  output logic [NUM_CPU-1:0]                devIrq
);
  logic [NUM_SRC-1:0]              sumNext;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] maskNext;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] effNext;
  logic [DATA_W-1:0]               rdVal;
  logic [NUM_SRC-1:0]              wrVal;

  assign wrVal = regWdata[NUM_SRC-1:0];

  // a clear only acts on a pending bit; a coincident set re-arms it
  assign sumNext = (summaryQ & ~srcClr) | srcSet;

  always_ff @(posedge clk) begin
    if (!rstN) summaryQ <= '0;
    else       summaryQ <= sumNext;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign maskNext[c] = (stb.wrMask && stb.idx == IDX_W'(c)) ? wrVal : maskQ[c];
    assign effNext[c]  = maskNext[c] & sumNext;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[c]  <= '0;
        effQ[c]   <= '0;
        devIrq[c] <= 1'b0;
      end else begin
        maskQ[c]  <= maskNext[c];
        effQ[c]   <= effNext[c];
        devIrq[c] <= |effNext[c];
      end
    end
  end

  always_comb begin
    rdVal = '0;
    case (stb.rdSel)
      SEL_SUM: rdVal[NUM_SRC-1:0] = summaryQ;
      SEL_MASK: begin
        for (int c = 0; c < NUM_CPU; c++)
          if (stb.idx == IDX_W'(c)) rdVal[NUM_SRC-1:0] = maskQ[c];
      end
      SEL_EFF: begin
        for (int c = 0; c < NUM_CPU; c++)
          if (stb.idx == IDX_W'(c)) rdVal[NUM_SRC-1:0] = effQ[c];
      end
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= stb.ack;
      rspErr   <= stb.err;
      rspData  <= rdVal;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [3:0]         regBytes,
  input  logic [DATA_W-1:0]  regWdata,
  output logic               rspValid,
  output logic               rspErr,
  output logic [DATA_W-1:0]  rspData,
  output logic [NUM_CPU-1:0] devIrq
);
  reg_stb_t                        stb;
  logic [NUM_SRC-1:0]              summaryQ;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] maskQ;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] effQ;

  irq_router_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_ctrl (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .regBytes(regBytes),
    .stb     (stb)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcSet  (srcSet),
    .srcClr  (srcClr),
    .stb     (stb),
    .regWdata(regWdata),
    .rspValid(rspValid),
    .rspErr  (rspErr),
    .rspData (rspData),
    .summaryQ(summaryQ),
    .maskQ   (maskQ),
    .effQ    (effQ),
    .devIrq  (devIrq)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [NUM_SRC-1:0]              srcSet,
  input logic [NUM_SRC-1:0]              srcClr,
  input logic                            regValid,
  input logic                            rspValid,
  input logic                            rspErr,
  input logic [NUM_CPU-1:0]              devIrq,
  input logic [NUM_SRC-1:0]              summaryQ,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] maskQ,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] effQ
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assert_eff_and_R2: assert property (@(posedge clk) disable iff (!rstN)
      effQ[c] == (maskQ[c] & summaryQ));
    assert_irq_or_R10: assert property (@(posedge clk) disable iff (!rstN)
      devIrq[c] == (|effQ[c]));
  end

  assert_set_sticks_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|srcSet) |=> ((summaryQ & $past(srcSet)) == $past(srcSet)));

  assert_spurious_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcClr & ~summaryQ & ~srcSet)) |=>
      ((summaryQ & $past(srcClr & ~summaryQ & ~srcSet)) == '0));

  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    regValid |=> rspValid);

  assert_no_extra_rsp_R7: assert property (@(posedge clk) disable iff (!rstN)
    !regValid |=> !rspValid);

  assert_err_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (maskQ == $past(maskQ)));
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int NS = 64;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcSet = '0;
  logic [NS-1:0] srcClr = '0;
  logic          regValid = 1'b0;
  logic          regWrite = 1'b0;
  logic [15:0]   regAddr = '0;
  logic [3:0]    regBytes = 4'd8;
  logic [63:0]   regWdata = '0;
  logic          rspValid;
  logic          rspErr;
  logic [63:0]   rspData;
  logic [NC-1:0] devIrq;

  irq_router dut (.*);

  always #2.5 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 0;
  string curReq = "R10";
  string expTag = "R10";

  logic [63:0]   refMask [NC];
  logic [63:0]   refSum = '0;
  logic          expV = 0, expE = 0;
  logic [63:0]   expD = '0;
  logic [NC-1:0] expIrq = '0;

  // 0 illegal, 1 summary, 2 mask, 3 effective
  function automatic int classify(input logic [15:0] a, input logic [3:0] b,
                                  input logic w, output int cpu);
    int k, n;
    cpu = 0;
    if (b != 4'd8) return 0;
    if (a[15] || a[14]) begin
      if (a[3:0] != 0 || a[13:10] != 0) return 0;
      cpu = int'(a[9:4]);
      if (cpu >= NC) return 0;
      k = a[15] ? 2 : 3;
    end else begin
      if (a[5:0] != 0) return 0;
      n = int'(a[13:6]);
      if (n == 0) k = 1;
      else if (n <= NC) begin k = 2; cpu = n - 1; end
      else if (n <= 2 * NC) begin k = 3; cpu = n - 1 - NC; end
      else return 0;
    end
    if (w && k != 2) return 0;
    return k;
  endfunction

  always @(posedge clk) begin
    int k, cpu;
    if (!rstN) begin
      for (int c = 0; c < NC; c++) refMask[c] = '0;
      refSum = '0; expV = 0; expE = 0; expD = '0; expIrq = '0;
    end else begin
      k = classify(regAddr, regBytes, regWrite, cpu);
      expV = regValid;
      expE = regValid && k == 0;
      expD = '0;
      if (regValid && !regWrite) begin
        if (k == 1) expD = refSum;
        else if (k == 2) expD = refMask[cpu];
        else if (k == 3) expD = refMask[cpu] & refSum;
      end
      if (regValid && regWrite && k == 2) refMask[cpu] = regWdata;
      refSum = (refSum & ~srcClr) | srcSet;
      for (int c = 0; c < NC; c++) expIrq[c] = |(refMask[c] & refSum);
    end
    expTag = curReq;
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      vectors++;
      if (devIrq !== expIrq) begin
        fails++;
        $display("FAIL %s devIrq actual=%b expected=%b", expTag, devIrq, expIrq);
      end
      if (rspValid !== expV) begin
        fails++;
        $display("FAIL %s rspValid actual=%b expected=%b", expTag, rspValid, expV);
      end
      if (expV && (rspErr !== expE || rspData !== expD)) begin
        fails++;
        $display("FAIL %s rsp actual err=%b data=%h expected err=%b data=%h",
                 expTag, rspErr, rspData, expE, expD);
      end
    end
  end

  task automatic step(input logic [63:0] s, input logic [63:0] c, input logic v,
                      input logic w, input logic [15:0] a, input logic [3:0] b,
                      input logic [63:0] d, input string req);
    curReq = req;
    srcSet = s; srcClr = c; regValid = v; regWrite = w;
    regAddr = a; regBytes = b; regWdata = d;
    @(negedge clk);
    srcSet = '0; srcClr = '0; regValid = 0; regWrite = 0;
    regAddr = '0; regBytes = 4'd8; regWdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    step('0, '0, 1, 0, a, 4'd8, '0, req);
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input string req);
    step('0, '0, 1, 1, a, 4'd8, d, req);
  endtask

  task automatic ev(input logic [63:0] s, input logic [63:0] c, input string req);
    step(s, c, 0, 0, '0, 4'd8, '0, req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    curReq = "R10";
    ev('0, '0, "R10");
    rd(16'h0000, "R7");
    wr(16'h0040, 64'h1, "R7");
    wr(16'h8010, 64'h3, "R8");
    rd(16'h0080, "R7");
    ev(64'h1, '0, "R1");
    ev(64'h2, '0, "R1");
    rd(16'h0140, "R7");
    rd(16'h4010, "R8");
    rd(16'hC010, "R8");
    wr(16'h0040, 64'h0, "R3");
    wr(16'h0040, 64'h2, "R3");
    wr(16'h80F0, 64'hFF, "R9");
    ev('0, 64'h1, "R4");
    ev('0, 64'h2, "R4");
    ev('0, 64'h2, "R5");
    ev('0, 64'h8000_0000_0000_0000, "R5");
    rd(16'h0000, "R5");
    ev(64'h20, 64'h20, "R6");
    rd(16'h0000, "R6");
    ev('0, 64'h20, "R4");
    ev(64'h40, 64'h40, "R6");
    step(64'h100, '0, 1, 1, 16'h00C0, 4'd8, 64'h100, "R3");
    rd(16'h0180, "R2");
    wr(16'h0000, 64'hFFFF, "R9");
    wr(16'h0140, 64'hFFFF, "R9");
    step('0, '0, 1, 1, 16'h0040, 4'd4, 64'hFFFF, "R9");
    rd(16'h0040, "R9");
    rd(16'h0044, "R9");
    rd(16'h8040, "R9");
    rd(16'h0500, "R9");
    rd(16'h8018, "R9");
    rd(16'h8410, "R9");
    wr(16'h0100, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    ev(64'h8000_0000_0000_0000, '0, "R1");
    ev('0, 64'h8000_0000_0000_0000, "R4");
    for (int i = 0; i < 600; i++) begin
      logic [63:0] s, c, d;
      logic [15:0] a;
      logic        v, w;
      int          pick;
      s = ($urandom % 3 == 0) ? (64'h1 << ($urandom % 64)) : '0;
      c = ($urandom % 3 == 0) ? (64'h1 << ($urandom % 64)) : '0;
      if ($urandom % 8 == 0) c = s;
      v = ($urandom % 2) == 0;
      w = ($urandom % 2) == 0;
      d = {$urandom, $urandom} & {$urandom, $urandom};
      pick = $urandom % 8;
      case (pick)
        0: a = 16'h0000;
        1: a = 16'(64 * (1 + $urandom % 4));
        2: a = 16'(64 * (5 + $urandom % 4));
        3: a = 16'h8000 | 16'(16 * ($urandom % 5));
        4: a = 16'h4000 | 16'(16 * ($urandom % 5));
        5: a = 16'hC000 | 16'(16 * ($urandom % 4));
        6: a = 16'(64 * ($urandom % 12));
        default: a = 16'($urandom);
      endcase
      step(s, c, v, w, a, (($urandom % 10) == 0) ? 4'd4 : 4'd8, d, "R2");
    end
    for (int c = 1; c <= 2 * NC; c++) rd(16'(64 * c), "R2");
    rd(16'h0000, "R2");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule